// File: doc/BRIEF.md
# Phase-Frequency Detector with Speed-Up Pump Gating

This block sits between the reference divider, the main divider and the charge-pump drivers of a frequency synthesizer. It turns the rising edges of the two divider outputs into UP and DOWN drive for the normal charge pump. While both drives are high it holds them for a short, programmable overlap before clearing them together, so that very small phase errors still produce a measurable pulse and no dead zone appears.

A second pair of drives feeds a speed-up pump. That pair follows the normal pair only while a latched fast-mode flag is set. The fast-mode request, and the fast-to-normal current ratio passed on to the pump control, are taken in only between comparison cycles, when neither drive is active. Switching speed therefore never cuts a correction pulse short.

A lock-indicator output is high for exactly the time that one drive is active without the other. A mask bit can silence it. A power-down input forces every drive and the lock output low and clears the detector state.

Top module: `pfd_speedup`

## Requirements
- R1: A rising edge (a low-to-high change between two sampled cycles) on `ref_div` sets `pump_up` from the next cycle, and a rising edge on `main_div` sets `pump_dn` from the next cycle. Once set, each stays high until the overlap clear of R2 or power-down.
- R2: When both drives are high they stay high for exactly `RST_DLY` cycles and then clear together. Edges that arrive during this overlap are ignored.
- R3: `fast_req` is copied into an internal fast flag only on a clock edge at which both normal drives are low. `fast_up` and `fast_dn` equal `pump_up` and `pump_dn` while that flag is set.
- R4: When `lock_en` is 1, `lock_out` is 1 exactly when one normal drive is high and the other is low. When `lock_en` is 0, `lock_out` is 0.
- R5: While `pwr_dn` is 1, all pump drives and `lock_out` are 0 in the same cycle. The detector state and the fast flag are cleared, so no drive is active on the cycle after `pwr_dn` falls.
- R6: `ratio_out` takes the value of `ratio_cfg` only on a clock edge at which both normal drives are low and `pwr_dn` is 0. Otherwise it holds its value.
- R7: After synchronous reset, all drive outputs, `lock_out` and `ratio_out` are 0.
- R8: While the fast flag is clear, `fast_up` and `fast_dn` stay 0 even when the normal drives are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_div | input | 1 | Reference divider output |
| main_div | input | 1 | Main divider output |
| fast_req | input | 1 | Speed-up mode request |
| pwr_dn | input | 1 | Power-down, active high |
| lock_en | input | 1 | Enable for the lock-indicator output |
| ratio_cfg | input | RATIO_W | Programmed fast/normal current ratio |
| pump_up | output | 1 | Normal pump UP drive |
| pump_dn | output | 1 | Normal pump DOWN drive |
| fast_up | output | 1 | Speed-up pump UP drive |
| fast_dn | output | 1 | Speed-up pump DOWN drive |
| lock_out | output | 1 | Phase-error-width lock pulse |
| ratio_out | output | RATIO_W | Ratio delivered to the pump control |

## Verification
The bench builds the block with `RST_DLY` = 3 rather than the default 2. This lets the overlap counter pass through a middle value, and it widens the window in which late edges must be ignored. `RATIO_W` = 5 gives the ratio path a width different from the default, so a truncated or misrouted bit shows up in `ratio_out`. Sparse random divider pulses, together with occasional fast, mask and power-down toggles, drive the design into mid-cycle fast requests and power-down during overlap.

// File: rtl/pfd_speedup_pkg.sv
package pfd_speedup_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_pair_t;

    localparam pump_pair_t PAIR_IDLE = '{up: 1'b0, dn: 1'b0};

    function automatic pump_pair_t gate_pair(pump_pair_t p, logic en);
        pump_pair_t g;
        g.up = p.up & en;
        g.dn = p.dn & en;
        return g;
    endfunction

    function automatic logic phase_err(pump_pair_t p);
        return p.up ^ p.dn;
    endfunction

    function automatic logic pair_idle(pump_pair_t p);
        return !p.up && !p.dn;
    endfunction

endpackage

// File: rtl/pfd_speedup_edge.sv
module pfd_speedup_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= level_in[i];
        end
        assign rise[i] = level_in[i] & ~prev_q[i];
    end
endmodule

// File: rtl/pfd_speedup_core.sv
module pfd_speedup_core
    import pfd_speedup_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd,
    input  logic       ref_edge,
    input  logic       main_edge,
    output pump_pair_t drive,
    output logic       idle
);
    localparam int CW = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_DLY - 1);

    pump_pair_t    q;
    logic [CW-1:0] cnt;
    logic          both;

    assign both = q.up & q.dn;

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            q   <= PAIR_IDLE;
            cnt <= '0;
        end else if (both) begin
            if (cnt == LAST) begin
                q   <= PAIR_IDLE;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            q.up <= q.up | ref_edge;
            q.dn <= q.dn | main_edge;
        end
    end

    assign drive = q;
    assign idle  = pair_idle(q);

    p_set_up_r1: assert property (@(posedge clk) disable iff (rst)
        (ref_edge && !pd && !both) |=> q.up);
    p_set_dn_r1: assert property (@(posedge clk) disable iff (rst)
        (main_edge && !pd && !both) |=> q.dn);
    p_overlap_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (both && cnt == LAST) |=> (!q.up && !q.dn));
    p_overlap_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (both && cnt != LAST && !pd) |=> (q.up && q.dn));
endmodule

// File: rtl/pfd_speedup_gate.sv
module pfd_speedup_gate #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pd,
    input  logic               idle,
    input  logic               fast_req,
    input  logic [RATIO_W-1:0] ratio_cfg,
    output logic               fast_act,
    output logic [RATIO_W-1:0] ratio_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fast_act <= 1'b0;
            ratio_q  <= '0;
        end else if (pd) begin
            fast_act <= 1'b0;
        end else if (idle) begin
            fast_act <= fast_req;
            ratio_q  <= ratio_cfg;
        end
    end

    p_fast_sync_r3: assert property (@(posedge clk) disable iff (rst)
        (!idle && !pd) |=> $stable(fast_act));
    p_ratio_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!idle || pd) |=> $stable(ratio_q));
endmodule

// File: rtl/pfd_speedup.sv
module pfd_speedup
    import pfd_speedup_pkg::*;
#(
    parameter int RST_DLY = 2,
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_div,
    input  logic               main_div,
    input  logic               fast_req,
    input  logic               pwr_dn,
    input  logic               lock_en,
    input  logic [RATIO_W-1:0] ratio_cfg,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               fast_up,
    output logic               fast_dn,
    output logic               lock_out,
    output logic [RATIO_W-1:0] ratio_out
);
    logic [1:0] rise;
    pump_pair_t drive, norm, spd;
    logic       idle, fast_act;

    pfd_speedup_edge #(.N(2)) u_edge (
        .clk(clk), .rst(rst), .level_in({main_div, ref_div}), .rise(rise)
    );

    pfd_speedup_core #(.RST_DLY(RST_DLY)) u_core (
        .clk(clk), .rst(rst), .pd(pwr_dn),
        .ref_edge(rise[0]), .main_edge(rise[1]),
        .drive(drive), .idle(idle)
    );

    pfd_speedup_gate #(.RATIO_W(RATIO_W)) u_gate (
        .clk(clk), .rst(rst), .pd(pwr_dn), .idle(idle),
        .fast_req(fast_req), .ratio_cfg(ratio_cfg),
        .fast_act(fast_act), .ratio_q(ratio_out)
    );

    assign norm     = gate_pair(drive, ~pwr_dn);
    assign spd      = gate_pair(norm, fast_act);
    assign pump_up  = norm.up;
    assign pump_dn  = norm.dn;
    assign fast_up  = spd.up;
    assign fast_dn  = spd.dn;
    assign lock_out = phase_err(norm) & lock_en;

    p_lock_mask_r4: assert property (@(posedge clk) disable iff (rst)
        !lock_en |-> !lock_out);
    p_pd_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |-> !(pump_up || pump_dn || fast_up || fast_dn || lock_out));
    p_fast_subset_r3: assert property (@(posedge clk) disable iff (rst)
        (fast_up |-> pump_up) and (fast_dn |-> pump_dn));
    p_pd_clears_r5: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (!fast_up && !fast_dn));
endmodule

// File: tb/pfd_speedup_bench.sv
module pfd_speedup_bench;
    localparam int RST_DLY = 3;
    localparam int RATIO_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_div = 0, main_div = 0, fast_req = 0, pwr_dn = 0, lock_en = 0;
    logic [RATIO_W-1:0] ratio_cfg = '0;
    logic pump_up, pump_dn, fast_up, fast_dn, lock_out;
    logic [RATIO_W-1:0] ratio_out;

    always #4 clk = ~clk;

    pfd_speedup #(.RST_DLY(RST_DLY), .RATIO_W(RATIO_W)) u_pfd_speedup (
        .clk(clk), .rst(rst), .ref_div(ref_div), .main_div(main_div),
        .fast_req(fast_req), .pwr_dn(pwr_dn), .lock_en(lock_en),
        .ratio_cfg(ratio_cfg), .pump_up(pump_up), .pump_dn(pump_dn),
        .fast_up(fast_up), .fast_dn(fast_dn), .lock_out(lock_out),
        .ratio_out(ratio_out)
    );

    int compared = 0, mismatched = 0, cycles = 0;
    bit model_on = 0;

    // Reference model: state that the requirements define.
    logic m_up = 0, m_dn = 0, m_fast = 0, m_pr = 0, m_pm = 0;
    int   m_cnt = 0;
    logic [RATIO_W-1:0] m_ratio = '0;

    always @(posedge clk) begin
        logic re, me, idl;
        cycles++;
        if (rst) begin
            m_up = 0; m_dn = 0; m_fast = 0; m_pr = 0; m_pm = 0;
            m_cnt = 0; m_ratio = '0;
        end else begin
            re  = ref_div & ~m_pr;
            me  = main_div & ~m_pm;
            idl = !m_up && !m_dn;
            if (pwr_dn) m_fast = 0;
            else if (idl) begin m_fast = fast_req; m_ratio = ratio_cfg; end // R3 R6
            if (pwr_dn) begin m_up = 0; m_dn = 0; m_cnt = 0; end            // R5
            else if (m_up && m_dn) begin                                     // R2
                if (m_cnt == RST_DLY - 1) begin m_up = 0; m_dn = 0; m_cnt = 0; end
                else m_cnt++;
            end else begin m_up |= re; m_dn |= me; end                       // R1
            m_pr = ref_div; m_pm = main_div;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic exp_lock(logic u, logic d, logic en, logic pd);
        return (u ^ d) & en & ~pd;
    endfunction

    always @(negedge clk) begin
        if (model_on && !rst) begin
            logic eu, ed;
            eu = m_up & ~pwr_dn;
            ed = m_dn & ~pwr_dn;
            chk("R1/R2/R5 pump_up", pump_up, eu);
            chk("R1/R2/R5 pump_dn", pump_dn, ed);
            chk("R3/R8 fast_up", fast_up, eu & m_fast);
            chk("R3/R8 fast_dn", fast_dn, ed & m_fast);
            chk("R4 lock_out", lock_out, exp_lock(m_up, m_dn, lock_en, pwr_dn));
            chk("R6 ratio_out", ratio_out, m_ratio);
        end
    end

    task automatic step(logic r, logic m);
        @(posedge clk); #2;
        ref_div = r; main_div = m;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        chk("R7 reset pumps", {pump_up, pump_dn, fast_up, fast_dn, lock_out}, 0);
        chk("R7 reset ratio", ratio_out, 0);
        @(posedge clk); #2;
        rst = 0; lock_en = 1; ratio_cfg = 5'h15;
        model_on = 1;
        // R1: reference edge sets UP; R8: no speed-up drive when fast is off
        step(1, 0); step(0, 0);
        @(negedge clk);
        chk("R1 up after ref edge", pump_up, 1);
        chk("R8 fast_up idle flag", fast_up, 0);
        chk("R4 lock during error", lock_out, 1);
        // R3: fast request mid-cycle must not reach the speed-up pump
        fast_req = 1;
        step(0, 1); step(0, 0);
        @(negedge clk);
        chk("R2 overlap both high", {pump_up, pump_dn}, 2'b11);
        chk("R3 fast not mid-cycle", fast_up, 0);
        chk("R6 ratio held busy", ratio_out, 5'h15);
        ratio_cfg = 5'h0A;
        repeat (RST_DLY + 2) step(0, 0);
        @(negedge clk);
        chk("R2 cleared after overlap", {pump_up, pump_dn}, 2'b00);
        chk("R6 ratio loaded idle", ratio_out, 5'h0A);
        // R3: now fast flag set, speed-up follows
        step(0, 1); step(0, 0);
        @(negedge clk);
        chk("R3 fast_dn follows", fast_dn, 1);
        // R4: mask
        lock_en = 0;
        @(negedge clk);
        chk("R4 lock masked", lock_out, 0);
        lock_en = 1;
        // R5: power-down during error
        @(posedge clk); #2; pwr_dn = 1;
        @(negedge clk);
        chk("R5 pd quiet", {pump_up, pump_dn, fast_up, fast_dn, lock_out}, 0);
        step(0, 0); pwr_dn = 0; fast_req = 0;
        @(negedge clk);
        chk("R5 state cleared", {pump_up, pump_dn}, 0);
        // constrained random phase
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk); #2;
            ref_div  = ($urandom % 6) == 0;
            main_div = ($urandom % 6) == 0;
            if (($urandom % 40) == 0) fast_req = ~fast_req;
            if (($urandom % 50) == 0) lock_en  = ~lock_en;
            if (($urandom % 90) == 0) pwr_dn   = 1;
            else if (($urandom % 4) == 0) pwr_dn = 0;
            ratio_cfg = RATIO_W'($urandom);
        end
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule